// File: doc/BRIEF.md
# SRAM-Style External Bus Cycle Generator

This block turns single read or write commands from the chip's internal side into timed cycles on an external bus. The bus follows asynchronous static-RAM conventions. For every cycle it drives a one-clock bus-start marker, a chip select, a read strobe that can serve as output enable, and one write enable for each byte lane. All of these are active-low. The address and write data are captured when the cycle starts and stay stable until it ends.

Timing comes from configuration inputs that are sampled when each cycle starts:
- a programmed wait count, which saturates at 25;
- the number of clocks chip select and address lead the strobes (setup, 0 to 7);
- the number of clocks they trail the strobes (hold, 0 to 7);
- an option that widens the bus-start marker to two clocks when setup is nonzero;
- the external bus width, 16 or 32 bits.

An active-low ready input can stretch a cycle beyond the programmed waits, but only when the programmed wait count is nonzero.

On the internal side, a one-clock `req` pulse is accepted whenever the block is free. The block is free when idle, or during the final clock of a cycle, which is the clock in which `ack` is high. A request accepted in that final clock starts the next cycle straight away, so chip select stays low across the boundary.

Top module: `sram_cycle_gen`

## Requirements
- R1: After reset, `cs_n`, `bus_start_n`, `rd_n` and all bits of `we_n` are high, and `ack` is low.
- R2: With waits, setup and hold all zero, an accepted request gives a cycle of exactly two clocks with `cs_n` low. `ack` is high only in the second of these clocks and never for two consecutive clocks.
- R3: `bus_start_n` is low in the first clock of every cycle. Unless R9 applies, it is low for that one clock only.
- R4: A request accepted in the clock where `ack` is high starts a new cycle at the next edge. `cs_n` stays low with no high gap, and `bus_start_n` goes low again.
- R5: The strobe phase lasts W+2 clocks, where W is the programmed wait. A `cfg_wait` value above 25 behaves as 25.
- R6: With W>0, `rdy_n` is sampled at the edge closing the last programmed wait clock, and again at each edge after that. Every sample taken high adds one more strobe clock. The first sample taken low lets the final strobe clock follow.
- R7: With W=0, `rdy_n` has no effect: the strobe phase is two clocks whatever its level.
- R8: Chip select goes low `cfg_setup` clocks before the strobes start and stays low `cfg_hold` clocks after they end, with the strobes high in both spans. The whole cycle then lasts setup + (W+2) + hold clocks, and `ack` falls in its last clock.
- R9: With `cfg_bs_hold`=1 and setup of 1 or more, `bus_start_n` is low for the first two clocks of the cycle. With setup 0, it stays a single clock.
- R10: During a write strobe, `we_n[i]` is low only for byte lanes i with `req_be[i]`=1. Lane i carries data bits 8i+7..8i, and `rd_n` stays high. With `cfg_bus32`=0 (16-bit bus), lanes 2 and 3 never go low.
- R11: During a read strobe, `rd_n` is low and all `we_n` are high. `rd_data` takes the bus value captured at the edge closing the last strobe clock, over the full bus width whatever `req_be` is. On a 16-bit bus, bits 31..16 read as zero. `rd_data` is updated at the edge that ends the `ack` clock.
- R12: A `req` pulse that arrives while a cycle is running, outside its `ack` clock, is dropped: no further cycle follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | One-clock request pulse |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_be | input | DW/8 | Byte enables, bit i = lane i |
| req_wdata | input | DW | Write data |
| ack | output | 1 | High in the final clock of a cycle |
| rd_data | output | DW | Registered read data |
| cfg_wait | input | WAIT_W | Programmed wait count, saturates at MAX_WAIT |
| cfg_setup | input | SH_W | Setup clocks before the strobes |
| cfg_hold | input | SH_W | Hold clocks after the strobes |
| cfg_bs_hold | input | 1 | Widen bus-start to two clocks when setup is nonzero |
| cfg_bus32 | input | 1 | 1 = 32-bit bus, 0 = 16-bit bus |
| bus_addr | output | AW | External address |
| bus_start_n | output | 1 | Bus-start marker, active-low |
| cs_n | output | 1 | Chip select, active-low |
| rd_n | output | 1 | Read strobe / output enable, active-low |
| we_n | output | DW/8 | Per-lane write enables, active-low |
| dout | output | DW | Write data to the bus |
| dout_en | output | 1 | Drive enable for `dout` during write cycles |
| din | input | DW | Read data from the bus |
| rdy_n | input | 1 | External ready, active-low |

## Verification
The assertions assume the cycle has at least two clocks, so `ack` and a widened bus-start can never overlap a fresh start. They also take timing fields only from the values latched at the start edge, so a configuration change in mid-cycle cannot break them. The stimulus drives `req` as a single-clock pulse and holds `rdy_n` low outside strobe clocks. It raises `rdy_n` only over a counted window of strobe clocks, so every stretched cycle is released after a known number of samples. Bus read data is switched to a different value once the strobes end, which exposes any late capture.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  // Phases of one external bus cycle
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_STRB  = 2'd2,
    PH_HOLD  = 2'd3
  } phase_e;

endpackage

// File: rtl/sramc_rst_sync.sv
module sramc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/sramc_seq.sv
module sramc_seq
  import sramc_pkg::*;
#(
  parameter int WAIT_W   = 5,
  parameter int MAX_WAIT = 25,
  parameter int SH_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic [SH_W-1:0]   cfg_setup,
  input  logic [SH_W-1:0]   cfg_hold,
  input  logic              cfg_bs_hold,
  input  logic              rdy_n,
  output logic              start,
  output logic              cs_on,
  output logic              strb_on,
  output logic              bs_on,
  output logic              ack,
  output logic              strb_end
);

  localparam int SH_MAX  = (1 << SH_W) - 1;
  localparam int CNT_MAX = (MAX_WAIT + 1 > SH_MAX) ? MAX_WAIT + 1 : SH_MAX;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [WAIT_W-1:0] WAIT_CAP = WAIT_W'(MAX_WAIT);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

  phase_e            ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WAIT_W-1:0] wait_q, wait_d, wait_eff;
  logic [SH_W-1:0]   hold_q, hold_d;
  logic              bsx_q, bsx_d;
  logic              cs_q, cs_d;
  logic              strb_q, strb_d;
  logic              bs_q, bs_d;
  logic              ack_q, ack_d;
  logic              free;

  // Next-state logic
  always_comb begin
    wait_eff = (cfg_wait > WAIT_CAP) ? WAIT_CAP : cfg_wait;
    free     = (ph_q == PH_IDLE) || ack_q;
    start    = free && req;

    ph_d   = ph_q;
    cnt_d  = cnt_q;
    wait_d = wait_q;
    hold_d = hold_q;
    bsx_d  = 1'b0;

    if (start) begin
      wait_d = wait_eff;
      hold_d = cfg_hold;
      bsx_d  = cfg_bs_hold && (cfg_setup != '0);
      if (cfg_setup != '0) begin
        ph_d  = PH_SETUP;
        cnt_d = CNT_W'(cfg_setup) - CNT_ONE;
      end else begin
        ph_d  = PH_STRB;
        cnt_d = CNT_W'(wait_eff) + CNT_ONE;
      end
    end else begin
      case (ph_q)
        PH_SETUP: begin
          if (cnt_q == '0) begin
            ph_d  = PH_STRB;
            cnt_d = CNT_W'(wait_q) + CNT_ONE;
          end else begin
            cnt_d = cnt_q - CNT_ONE;
          end
        end
        PH_STRB: begin
          if (cnt_q == '0) begin
            if (hold_q != '0) begin
              ph_d  = PH_HOLD;
              cnt_d = CNT_W'(hold_q) - CNT_ONE;
            end else begin
              ph_d = PH_IDLE;
            end
          end else if ((cnt_q == CNT_ONE) && (wait_q != '0) && rdy_n) begin
            cnt_d = cnt_q;          // ready not yet given: extra wait clock
          end else begin
            cnt_d = cnt_q - CNT_ONE;
          end
        end
        PH_HOLD: begin
          if (cnt_q == '0) ph_d = PH_IDLE;
          else             cnt_d = cnt_q - CNT_ONE;
        end
        default: ph_d = PH_IDLE;
      endcase
    end

    cs_d   = (ph_d != PH_IDLE);
    strb_d = (ph_d == PH_STRB);
    bs_d   = start || (bs_q && bsx_q);
    ack_d  = (cnt_d == '0) &&
             (((ph_d == PH_STRB) && (hold_d == '0)) || (ph_d == PH_HOLD));
  end

  // State and output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      wait_q <= '0;
      hold_q <= '0;
      bsx_q  <= 1'b0;
      cs_q   <= 1'b0;
      strb_q <= 1'b0;
      bs_q   <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      wait_q <= wait_d;
      hold_q <= hold_d;
      bsx_q  <= bsx_d;
      cs_q   <= cs_d;
      strb_q <= strb_d;
      bs_q   <= bs_d;
      ack_q  <= ack_d;
    end
  end

  assign cs_on    = cs_q;
  assign strb_on  = strb_q;
  assign bs_on    = bs_q;
  assign ack      = ack_q;
  assign strb_end = (ph_q == PH_STRB) && (cnt_q == '0);

  // R2: completion marker lasts one clock only
  assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);

  // R4: completion is always inside an active chip select
  assert_ack_in_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> cs_q);

  // R5: latched wait never exceeds the cap
  assert_wait_capped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q <= WAIT_CAP);

  // R3: a non-widened bus-start marker ends after one clock
  assert_bs_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bs_q && !bsx_q) |=> !bs_q);

  // R8: strobes only inside chip select
  assert_strb_in_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strb_q |-> cs_q);

endmodule

// File: rtl/sramc_lanes.sv
module sramc_lanes #(
  parameter int DW = 32
) (
  input  logic            strb_on,
  input  logic            we,
  input  logic [DW/8-1:0] be,
  input  logic            bus32,
  input  logic [DW-1:0]   din,
  output logic            rd_n,
  output logic [DW/8-1:0] we_n,
  output logic [DW-1:0]   rdata
);

  localparam int NB   = DW / 8;
  localparam int HALF = NB / 2;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    localparam bit LOW_HALF = (i < HALF);
    logic live;
    assign live              = bus32 || LOW_HALF;
    assign we_n[i]           = !(strb_on && we && be[i] && live);
    assign rdata[8*i +: 8]   = live ? din[8*i +: 8] : 8'h00;
  end

  assign rd_n = !(strb_on && !we);

endmodule

// File: rtl/sram_cycle_gen.sv
module sram_cycle_gen #(
  parameter int AW       = 26,
  parameter int DW       = 32,
  parameter int WAIT_W   = 5,
  parameter int MAX_WAIT = 25,
  parameter int SH_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW/8-1:0]   req_be,
  input  logic [DW-1:0]     req_wdata,
  output logic              ack,
  output logic [DW-1:0]     rd_data,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic [SH_W-1:0]   cfg_setup,
  input  logic [SH_W-1:0]   cfg_hold,
  input  logic              cfg_bs_hold,
  input  logic              cfg_bus32,
  output logic [AW-1:0]     bus_addr,
  output logic              bus_start_n,
  output logic              cs_n,
  output logic              rd_n,
  output logic [DW/8-1:0]   we_n,
  output logic [DW-1:0]     dout,
  output logic              dout_en,
  input  logic [DW-1:0]     din,
  input  logic              rdy_n
);

  localparam int NB   = DW / 8;
  localparam int HALF = NB / 2;

  logic            rst_s_n;
  logic            start, cs_on, strb_on, bs_on, strb_end;
  logic [AW-1:0]   addr_q;
  logic            we_q, bus32_q;
  logic [NB-1:0]   be_q;
  logic [DW-1:0]   wd_q, cap_q, rd_q, rfmt;

  sramc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  sramc_seq #(
    .WAIT_W   (WAIT_W),
    .MAX_WAIT (MAX_WAIT),
    .SH_W     (SH_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .req         (req),
    .cfg_wait    (cfg_wait),
    .cfg_setup   (cfg_setup),
    .cfg_hold    (cfg_hold),
    .cfg_bs_hold (cfg_bs_hold),
    .rdy_n       (rdy_n),
    .start       (start),
    .cs_on       (cs_on),
    .strb_on     (strb_on),
    .bs_on       (bs_on),
    .ack         (ack),
    .strb_end    (strb_end)
  );

  sramc_lanes #(.DW(DW)) u_lanes (
    .strb_on (strb_on),
    .we      (we_q),
    .be      (be_q),
    .bus32   (bus32_q),
    .din     (din),
    .rd_n    (rd_n),
    .we_n    (we_n),
    .rdata   (rfmt)
  );

  // Request capture and read data registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      be_q    <= '0;
      wd_q    <= '0;
      bus32_q <= 1'b0;
      cap_q   <= '0;
      rd_q    <= '0;
    end else begin
      if (start) begin
        addr_q  <= req_addr;
        we_q    <= req_we;
        be_q    <= req_be;
        wd_q    <= req_wdata;
        bus32_q <= cfg_bus32;
      end
      if (strb_end) begin
        cap_q <= rfmt;
      end
      if (ack && !we_q) begin
        rd_q <= strb_end ? rfmt : cap_q;
      end
    end
  end

  assign bus_addr    = addr_q;
  assign bus_start_n = !bs_on;
  assign cs_n        = !cs_on;
  assign dout        = wd_q;
  assign dout_en     = cs_on && we_q;
  assign rd_data     = rd_q;

  // R3: every cycle opening from idle carries the bus-start marker
  assert_bs_at_open_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(cs_n) |-> !bus_start_n);

  // R10: upper lanes stay quiet on a 16-bit bus
  assert_upper_quiet_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    !bus32_q |-> (&we_n[NB-1:HALF]));

  // R11: read and write strobes never overlap
  assert_rd_we_excl_R11: assert property (@(posedge clk) disable iff (!rst_s_n)
    !rd_n |-> (&we_n));

  // R8: any strobe lies inside chip select
  assert_strobe_in_cs_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!rd_n || !(&we_n)) |-> !cs_n);

endmodule

// File: tb/sim_sram_cycle_gen.sv
module sim_sram_cycle_gen;

  logic        clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic        rst_n;
  logic        req, req_we;
  logic [25:0] req_addr;
  logic [3:0]  req_be;
  logic [31:0] req_wdata;
  logic        ack;
  logic [31:0] rd_data;
  logic [4:0]  cfg_wait;
  logic [2:0]  cfg_setup, cfg_hold;
  logic        cfg_bs_hold, cfg_bus32;
  logic [25:0] bus_addr;
  logic        bus_start_n, cs_n, rd_n;
  logic [3:0]  we_n;
  logic [31:0] dout;
  logic        dout_en;
  logic [31:0] din;
  logic        rdy_n;

  sram_cycle_gen u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .ack(ack), .rd_data(rd_data),
    .cfg_wait(cfg_wait), .cfg_setup(cfg_setup), .cfg_hold(cfg_hold),
    .cfg_bs_hold(cfg_bs_hold), .cfg_bus32(cfg_bus32), .bus_addr(bus_addr),
    .bus_start_n(bus_start_n), .cs_n(cs_n), .rd_n(rd_n), .we_n(we_n),
    .dout(dout), .dout_en(dout_en), .din(din), .rdy_n(rdy_n)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  // measurements of the last cycle
  int          m_cs, m_bs, m_setup, m_strb, m_hold, m_ack_pos, m_ack_cnt;
  logic [3:0]  m_we;
  logic        m_rd;
  logic [31:0] din_val;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic set_cfg(input int w, input int s, input int h, input logic bsh, input logic b32);
    cfg_wait    = 5'(w);
    cfg_setup   = 3'(s);
    cfg_hold    = 3'(h);
    cfg_bs_hold = bsh;
    cfg_bus32   = b32;
  endtask

  // Issue one request and measure the resulting bus cycle
  task automatic do_access(input logic w, input logic [3:0] be, input logic [31:0] wd,
                           input int extra_rdy);
    int w_eff, idx, sc;
    w_eff = (cfg_wait > 5'd25) ? 25 : int'(cfg_wait);
    @(negedge clk);
    req = 1'b1; req_we = w; req_be = be; req_wdata = wd; req_addr = 26'h12_3456;
    @(negedge clk);
    req = 1'b0;
    m_cs = 0; m_bs = 0; m_setup = 0; m_strb = 0; m_hold = 0;
    m_ack_pos = 0; m_ack_cnt = 0; m_we = 4'hF; m_rd = 1'b0;
    idx = 0; sc = 0;
    while (!cs_n && idx < 200) begin
      idx++;
      m_cs++;
      if (!bus_start_n) m_bs++;
      if (ack) begin m_ack_cnt++; m_ack_pos = idx; end
      if (!rd_n || we_n != 4'hF) begin
        sc++;
        m_strb++;
        if (we_n != 4'hF) m_we = we_n;
        if (!rd_n) m_rd = 1'b1;
        din   = din_val;
        rdy_n = (sc <= w_eff + extra_rdy) ? 1'b1 : 1'b0;
      end else begin
        if (sc == 0) m_setup++;
        else         m_hold++;
        din   = ~din_val;
        rdy_n = 1'b0;
      end
      @(negedge clk);
    end
    rdy_n = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 cs_n idle", 32'(cs_n), 32'd1);
    check("R1 bus_start_n idle", 32'(bus_start_n), 32'd1);
    check("R1 rd_n idle", 32'(rd_n), 32'd1);
    check("R1 we_n idle", 32'(we_n), 32'hF);
    check("R1 ack idle", 32'(ack), 32'd0);
  endtask

  task automatic t_basic;
    set_cfg(0, 0, 0, 1'b0, 1'b1);
    din_val = 32'hCAFE_0123;
    do_access(1'b0, 4'b0001, 32'h0, 0);
    check("R2 cycle length", 32'(m_cs), 32'd2);
    check("R2 ack position", 32'(m_ack_pos), 32'd2);
    check("R2 ack count", 32'(m_ack_cnt), 32'd1);
    check("R3 bus-start width", 32'(m_bs), 32'd1);
    check("R11 rd_n seen", 32'(m_rd), 32'd1);
    check("R11 full width read", rd_data, 32'hCAFE_0123);
  endtask

  task automatic t_back2back;
    set_cfg(0, 0, 0, 1'b0, 1'b1);
    @(negedge clk);
    req = 1'b1; req_we = 1'b0; req_be = 4'hF;
    @(negedge clk);
    req = 1'b0;
    check("R4 first T1 bus-start", 32'(bus_start_n), 32'd0);
    @(negedge clk);
    check("R4 first ack", 32'(ack), 32'd1);
    req = 1'b1; req_we = 1'b1; req_be = 4'hF; req_wdata = 32'h1111_2222;
    @(negedge clk);
    req = 1'b0;
    check("R4 no cs gap", 32'(cs_n), 32'd0);
    check("R4 second bus-start", 32'(bus_start_n), 32'd0);
    check("R4 second cycle writes", 32'(we_n), 32'h0);
    @(negedge clk);
    check("R4 second ack", 32'(ack), 32'd1);
    @(negedge clk);
    check("R4 idle after", 32'(cs_n), 32'd1);
  endtask

  task automatic t_waits;
    set_cfg(3, 0, 0, 1'b0, 1'b1);
    do_access(1'b0, 4'hF, 32'h0, 0);
    check("R5 strobe with 3 waits", 32'(m_strb), 32'd5);
    check("R5 cycle with 3 waits", 32'(m_cs), 32'd5);
    set_cfg(31, 0, 0, 1'b0, 1'b1);
    do_access(1'b0, 4'hF, 32'h0, 0);
    check("R5 saturated wait strobe", 32'(m_strb), 32'd27);
  endtask

  task automatic t_ready;
    set_cfg(2, 0, 0, 1'b0, 1'b1);
    do_access(1'b0, 4'hF, 32'h0, 3);
    check("R6 ready stretch strobe", 32'(m_strb), 32'd7);
    check("R6 ready stretch ack", 32'(m_ack_pos), 32'd7);
  endtask

  task automatic t_ready_ignored;
    set_cfg(0, 0, 0, 1'b0, 1'b1);
    do_access(1'b0, 4'hF, 32'h0, 3);
    check("R7 ready ignored strobe", 32'(m_strb), 32'd2);
  endtask

  task automatic t_setup_hold;
    set_cfg(1, 3, 2, 1'b0, 1'b1);
    din_val = 32'h5A5A_9876;
    do_access(1'b0, 4'hF, 32'h0, 0);
    check("R8 setup clocks", 32'(m_setup), 32'd3);
    check("R8 strobe clocks", 32'(m_strb), 32'd3);
    check("R8 hold clocks", 32'(m_hold), 32'd2);
    check("R8 cycle length", 32'(m_cs), 32'd8);
    check("R8 ack in last clock", 32'(m_ack_pos), 32'd8);
    check("R11 capture at strobe end", rd_data, 32'h5A5A_9876);
  endtask

  task automatic t_bs_hold;
    set_cfg(0, 2, 0, 1'b1, 1'b1);
    do_access(1'b0, 4'hF, 32'h0, 0);
    check("R9 widened bus-start", 32'(m_bs), 32'd2);
    set_cfg(0, 0, 0, 1'b1, 1'b1);
    do_access(1'b0, 4'hF, 32'h0, 0);
    check("R9 no widening without setup", 32'(m_bs), 32'd1);
  endtask

  task automatic t_write_lanes;
    set_cfg(0, 0, 0, 1'b0, 1'b1);
    do_access(1'b1, 4'b0101, 32'hDEAD_BEEF, 0);
    check("R10 lane pattern 32-bit", 32'(m_we), 32'hA);
    check("R10 rd_n quiet on write", 32'(m_rd), 32'd0);
    set_cfg(0, 0, 0, 1'b0, 1'b0);
    do_access(1'b1, 4'hF, 32'hDEAD_BEEF, 0);
    check("R10 lane pattern 16-bit", 32'(m_we), 32'hC);
  endtask

  task automatic t_read16;
    set_cfg(0, 0, 0, 1'b0, 1'b0);
    din_val = 32'hA5A5_1234;
    do_access(1'b0, 4'b0001, 32'h0, 0);
    check("R11 16-bit read zero-extended", rd_data, 32'h0000_1234);
  endtask

  task automatic t_busy_ignored;
    int acks, wes;
    set_cfg(2, 2, 0, 1'b0, 1'b1);
    @(negedge clk);
    req = 1'b1; req_we = 1'b0; req_be = 4'hF;
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    req = 1'b1; req_we = 1'b1; req_be = 4'hF;
    @(negedge clk);
    req = 1'b0;
    acks = 0; wes = 0;
    for (int k = 0; k < 40 && !cs_n; k++) begin
      if (ack) acks++;
      if (we_n != 4'hF) wes++;
      @(negedge clk);
    end
    check("R12 single completion", 32'(acks), 32'd1);
    check("R12 dropped write never strobes", 32'(wes), 32'd0);
    for (int k = 0; k < 3; k++) begin
      check("R12 stays idle", 32'(cs_n), 32'd1);
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    req = 1'b0; req_we = 1'b0; req_addr = '0; req_be = '0; req_wdata = '0;
    din = '0; din_val = '0; rdy_n = 1'b0;
    set_cfg(0, 0, 0, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_back2back();
    t_waits();
    t_ready();
    t_ready_ignored();
    t_setup_hold();
    t_bs_hold();
    t_write_lanes();
    t_read16();
    t_busy_ignored();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule